// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Byte Codec

This block guards one byte with four check bits, forming a 12-bit codeword in which each check bit sits at a power-of-two position and the data bits fill the remaining positions. The encode side accepts a byte and returns the codeword. The decode side accepts a codeword, recomputes the four check groups and builds a syndrome. The syndrome is the sum of the position weights of the groups that fail, so its value is the 1-based position of a single flipped bit. The decoder inverts that bit and returns the repaired byte, the repaired codeword, the syndrome and error flags.

Each side has its own valid strobe and one register stage. A result appears on the cycle after its input was accepted. The two sides are independent and may be used in the same cycle, for example with the encoder feeding a storage write and the decoder checking a storage read.

Top module: `hsec_codec`

## Requirements
- R1: Codeword positions run from 1 to 12, with position 1 on bit 11 (the MSB) of the codeword ports. Check bits sit at positions 1, 2, 4 and 8. Data bits d1..d8 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order, and d1 is bit 7 (the MSB) of the byte ports.
- R2: The check bit at position 2^k covers every position whose index has bit k set. The encoder sets each check bit so that its group, including itself, has an even number of ones.
- R3: The byte 8'b10011010 encodes to 12'b011100101010.
- R4: Decoding a valid codeword gives syndrome 0, both error flags low, an unchanged codeword and the original byte.
- R5: Decoding a codeword with exactly one inverted bit at position p (1..12), whether a check bit or a data bit, gives syndrome p and the error flag high with the uncorrectable flag low. The repaired codeword and byte equal the original ones.
- R6: When the syndrome is above 12, the error flag and the uncorrectable flag are both high. The codeword is passed through unchanged, and the byte is taken from the unrepaired codeword.
- R7: Each side's output valid equals its input valid of the previous cycle. Payload outputs are registered and refresh only on cycles with a valid input.
- R8: While reset is asserted, all outputs are zero.
- R9: Receiving 12'b011100101110 gives syndrome 10, repaired codeword 12'b011100101010 and byte 8'b10011010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Byte on enc_data_i is to be encoded |
| enc_data_i | input | 8 | Byte to encode, d1 in the MSB |
| enc_valid_o | output | 1 | enc_code_o holds a new codeword |
| enc_code_o | output | 12 | Encoded codeword, position 1 in the MSB |
| dec_valid_i | input | 1 | Codeword on dec_code_i is to be decoded |
| dec_code_i | input | 12 | Received codeword, position 1 in the MSB |
| dec_valid_o | output | 1 | Decoder outputs hold a new result |
| dec_data_o | output | 8 | Repaired byte |
| dec_code_o | output | 12 | Repaired codeword |
| dec_syn_o | output | 4 | Syndrome (position of the flipped bit, 0 if none) |
| dec_err_o | output | 1 | Syndrome is nonzero |
| dec_uncorr_o | output | 1 | Syndrome names no real position; nothing was repaired |

## Verification
A wrong group mask or a mismatched data slot shows up one cycle after the input. It appears as an encoded codeword that differs from the arithmetic model for some bytes, or as a syndrome that is off by a power of two for some flipped positions. Because every byte is encoded and every single flip of every codeword is decoded, each mask bit and each data slot is exercised within the first few thousand cycles. A correction that lands on the wrong bit, or a repair applied to an out-of-range syndrome, shows up on the same cycle as a repaired codeword that differs from the expected one. The double-flip sweep produces that case for syndromes 13 to 15.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    // True when v is a positive power of two: these positions hold check bits.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Fewest check bits r that let a syndrome address DATA_W + r positions.
    function automatic int par_bits(input int dw);
        int res;
        res = 0;
        for (int r = 1; r < 16; r++) begin
            if (res == 0 && (1 << r) >= dw + r + 1) begin
                res = r;
            end
        end
        return res;
    endfunction

    // 1-based data index carried at codeword position p (0 for check slots).
    function automatic int data_idx(input int p);
        int cnt;
        cnt = 0;
        for (int q = 1; q <= p; q++) begin
            if (!is_pow2(q)) begin
                cnt++;
            end
        end
        return is_pow2(p) ? 0 : cnt;
    endfunction

    // 1-based codeword position that carries 1-based data index i.
    function automatic int data_pos(input int i);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < 64; p++) begin
            if (!is_pow2(p) && res == 0) begin
                cnt++;
                if (cnt == i) begin
                    res = p;
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
    parameter int DATA_W = 8,
    localparam int PAR_W = hsec_pkg::par_bits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } enc_state_t;

    // Group k: positions whose index has bit k set (position-indexed form).
    function automatic logic [CODE_W:1] group_mask(input int k);
        logic [CODE_W:1] m;
        m = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (((p >> k) & 1) == 1) begin
                m[p] = 1'b1;
            end
        end
        return m;
    endfunction

    // Same group, expressed on the flat port vector (position 1 = MSB).
    function automatic logic [CODE_W-1:0] flat_mask(input int k);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (((p >> k) & 1) == 1) begin
                m[CODE_W-p] = 1'b1;
            end
        end
        return m;
    endfunction

    logic [CODE_W:1]   placed_d;   // data in its slots, check slots zero
    logic [CODE_W:1]   full_d;     // data plus check bits
    logic [PAR_W-1:0]  par_d;
    logic [CODE_W-1:0] flat_d;
    enc_state_t        st_d, st_q;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_place
        if (hsec_pkg::is_pow2(p)) begin : g_chk
            assign placed_d[p] = 1'b0;
            assign full_d[p]   = par_d[$clog2(p)];
        end else begin : g_dat
            assign placed_d[p] = data_i[DATA_W - hsec_pkg::data_idx(p)];
            assign full_d[p]   = placed_d[p];
        end
        assign flat_d[CODE_W-p] = full_d[p];
    end

    for (genvar k = 0; k < PAR_W; k++) begin : g_par
        localparam logic [CODE_W:1] MASK = group_mask(k);
        assign par_d[k] = ^(placed_d & MASK);
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.code = flat_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign code_o  = st_q.code;

    // Data bits pulled back out of the registered codeword.
    logic [DATA_W-1:0] held_data;
    for (genvar i = 1; i <= DATA_W; i++) begin : g_back
        assign held_data[DATA_W-i] = st_q.code[CODE_W - hsec_pkg::data_pos(i)];
    end

    AST_ENC_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == $past(valid_i)); // R7

    AST_ENC_DATA_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> held_data == $past(data_i)); // R1

    for (genvar k = 0; k < PAR_W; k++) begin : g_even
        localparam logic [CODE_W-1:0] FMASK = flat_mask(k);
        AST_ENC_EVEN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> ^(code_o & FMASK) == 1'b0); // R2
    end

endmodule

// File: rtl/hsec_decoder.sv
module hsec_decoder #(
    parameter int DATA_W = 8,
    localparam int PAR_W = hsec_pkg::par_bits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CODE_W-1:0] code_o,
    output logic [PAR_W-1:0]  syn_o,
    output logic              err_o,
    output logic              uncorr_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CODE_W-1:0] code;
        logic [PAR_W-1:0]  syn;
        logic              err;
        logic              uncorr;
    } dec_state_t;

    function automatic logic [CODE_W:1] group_mask(input int k);
        logic [CODE_W:1] m;
        m = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (((p >> k) & 1) == 1) begin
                m[p] = 1'b1;
            end
        end
        return m;
    endfunction

    logic [CODE_W:1]   rx_d;      // received, by position
    logic [CODE_W:1]   fixed_d;   // repaired, by position
    logic [PAR_W-1:0]  syn_d;
    logic              in_range_d;
    logic [CODE_W-1:0] fixed_flat_d;
    logic [DATA_W-1:0] data_d;
    dec_state_t        st_d, st_q;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        assign rx_d[p]                = code_i[CODE_W-p];
        assign fixed_d[p]             = rx_d[p] ^ (in_range_d && (syn_d == PAR_W'(p)));
        assign fixed_flat_d[CODE_W-p] = fixed_d[p];
    end

    // Each failing group adds its weight 2^k: bit k of the syndrome.
    for (genvar k = 0; k < PAR_W; k++) begin : g_syn
        localparam logic [CODE_W:1] MASK = group_mask(k);
        assign syn_d[k] = ^(rx_d & MASK);
    end

    assign in_range_d = (syn_d != '0) && (int'(syn_d) <= CODE_W);

    for (genvar i = 1; i <= DATA_W; i++) begin : g_data
        assign data_d[DATA_W-i] = fixed_d[hsec_pkg::data_pos(i)];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.data   = data_d;
            st_d.code   = fixed_flat_d;
            st_d.syn    = syn_d;
            st_d.err    = (syn_d != '0);
            st_d.uncorr = (syn_d != '0) && !in_range_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.valid;
    assign data_o   = st_q.data;
    assign code_o   = st_q.code;
    assign syn_o    = st_q.syn;
    assign err_o    = st_q.err;
    assign uncorr_o = st_q.uncorr;

    AST_DEC_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == $past(valid_i)); // R7

    AST_DEC_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && syn_o == '0) |-> (!err_o && !uncorr_o)); // R4

    AST_DEC_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> $countones(code_o ^ $past(code_i)) <= 1); // R5

    AST_DEC_UNCORR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (!uncorr_o || (code_o == $past(code_i) && err_o))); // R6

    AST_DEC_UNCORR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && uncorr_o) |-> int'(syn_o) > CODE_W); // R6

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
    parameter int DATA_W = 8,
    localparam int PAR_W = hsec_pkg::par_bits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CODE_W-1:0] dec_code_o,
    output logic [PAR_W-1:0]  dec_syn_o,
    output logic              dec_err_o,
    output logic              dec_uncorr_o
);

    hsec_encoder #(.DATA_W(DATA_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    hsec_decoder #(.DATA_W(DATA_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (dec_valid_i),
        .code_i   (dec_code_i),
        .valid_o  (dec_valid_o),
        .data_o   (dec_data_o),
        .code_o   (dec_code_o),
        .syn_o    (dec_syn_o),
        .err_o    (dec_err_o),
        .uncorr_o (dec_uncorr_o)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!enc_valid_o && !dec_valid_o && enc_code_o == '0
                    && dec_code_o == '0 && !dec_err_o && !dec_uncorr_o)); // R8

endmodule

// File: tb/hsec_codec_bench.sv
`timescale 1ns/1ps
module hsec_codec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic        enc_valid_o;
    logic [11:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [11:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [7:0]  dec_data_o;
    logic [11:0] dec_code_o;
    logic [3:0]  dec_syn_o;
    logic        dec_err_o;
    logic        dec_uncorr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hsec_codec u_hsec_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_code_o(dec_code_o), .dec_syn_o(dec_syn_o),
        .dec_err_o(dec_err_o), .dec_uncorr_o(dec_uncorr_o)
    );

    // Position p (1..12) lives at vector bit 12-p.
    function automatic bit is_chk(input int p);
        return (p == 1) || (p == 2) || (p == 4) || (p == 8);
    endfunction

    function automatic logic [11:0] model_encode(input logic [7:0] b);
        logic [12:1] c;
        logic [11:0] v;
        int di;
        c = '0;
        di = 7;
        for (int p = 1; p <= 12; p++) begin
            if (!is_chk(p)) begin
                c[p] = b[di];
                di--;
            end
        end
        for (int w = 1; w <= 8; w = w * 2) begin
            logic s;
            s = 1'b0;
            for (int p = 1; p <= 12; p++) begin
                if ((p & w) != 0 && p != w) s = s ^ c[p];
            end
            c[w] = s;
        end
        for (int p = 1; p <= 12; p++) v[12-p] = c[p];
        return v;
    endfunction

    function automatic logic [7:0] model_extract(input logic [11:0] v);
        logic [7:0] b;
        int di;
        di = 7;
        for (int p = 1; p <= 12; p++) begin
            if (!is_chk(p)) begin
                b[di] = v[12-p];
                di--;
            end
        end
        return b;
    endfunction

    function automatic logic [11:0] flip_pos(input logic [11:0] v, input int p);
        logic [11:0] r;
        r = v;
        r[12-p] = ~r[12-p];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge: drive one input on each side, check one cycle later.
    task automatic xfer(input logic [7:0] b, input logic [11:0] rx,
                        input logic [11:0] exp_code, input logic [7:0] exp_data,
                        input logic [3:0] exp_syn, input bit exp_err,
                        input bit exp_unc, input string req);
        enc_valid_i = 1'b1;
        enc_data_i  = b;
        dec_valid_i = 1'b1;
        dec_code_i  = rx;
        @(negedge clk);
        chk(enc_valid_o == 1'b1, "R7", "enc valid", enc_valid_o, 1);
        chk(enc_code_o == model_encode(b), "R2", "encode", enc_code_o, model_encode(b));
        chk(dec_valid_o == 1'b1, "R7", "dec valid", dec_valid_o, 1);
        chk(dec_syn_o == exp_syn, req, "syndrome", dec_syn_o, exp_syn);
        chk(dec_code_o == exp_code, req, "codeword", dec_code_o, exp_code);
        chk(dec_data_o == exp_data, req, "data", dec_data_o, exp_data);
        chk(dec_err_o == exp_err, req, "err", dec_err_o, exp_err);
        chk(dec_uncorr_o == exp_unc, req, "uncorr", dec_uncorr_o, exp_unc);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: everything zero under reset
        chk({enc_valid_o, dec_valid_o, dec_err_o, dec_uncorr_o} == 4'b0, "R8", "flags",
            {enc_valid_o, dec_valid_o, dec_err_o, dec_uncorr_o}, 0);
        chk(enc_code_o == '0 && dec_code_o == '0, "R8", "codes", {enc_code_o, dec_code_o}, 0);
        chk(dec_data_o == '0 && dec_syn_o == '0, "R8", "data/syn", {dec_data_o, dec_syn_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 and R9: fixed worked examples
        xfer(8'b10011010, 12'b011100101110, 12'b011100101010, 8'b10011010, 4'd10, 1, 0, "R9");
        chk(enc_code_o == 12'b011100101010, "R3", "example codeword", enc_code_o, 12'b011100101010);

        // R7: idle cycle drops both valids
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);
        chk(!enc_valid_o && !dec_valid_o, "R7", "idle valid", {enc_valid_o, dec_valid_o}, 0);
        chk(enc_code_o == 12'b011100101010, "R7", "enc hold", enc_code_o, 12'b011100101010);

        // R1: single data bit walks to its slot (d1 = MSB to position 3, etc.)
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            logic [11:0] c;
            b = 8'h80 >> i;
            c = model_encode(b);
            xfer(b, c, c, b, 4'd0, 0, 0, "R4");
            chk(model_extract(enc_code_o) == b, "R1", "data slot", model_extract(enc_code_o), b);
        end

        // R4 and R5: every byte, clean and with each single flip
        for (int b = 0; b < 256; b++) begin
            logic [11:0] c;
            c = model_encode(8'(b));
            xfer(8'(b), c, c, 8'(b), 4'd0, 0, 0, "R4");
            for (int p = 1; p <= 12; p++) begin
                xfer(8'(b), flip_pos(c, p), c, 8'(b), 4'(p), 1, 0, "R5");
            end
        end

        // R6: two flips; syndrome is p xor q, above 12 means no repair
        for (int s = 0; s < 4; s++) begin
            logic [7:0] b;
            logic [11:0] c;
            b = 8'(s * 77 + 5);
            c = model_encode(b);
            for (int p = 1; p <= 12; p++) begin
                for (int q = p + 1; q <= 12; q++) begin
                    logic [11:0] rx;
                    int syn;
                    rx = flip_pos(flip_pos(c, p), q);
                    syn = p ^ q;
                    if (syn > 12) begin
                        xfer(b, rx, rx, model_extract(rx), 4'(syn), 1, 1, "R6");
                    end else begin
                        logic [11:0] fx;
                        fx = flip_pos(rx, syn);
                        xfer(b, rx, fx, model_extract(fx), 4'(syn), 1, 0, "R5");
                    end
                end
            end
        end

        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);
        summary();
    end

endmodule